// File: doc/BRIEF.md
# Parallel flash command sequencer

This block is the command interpreter on the device side of a small parallel NOR flash. It watches host write cycles, each made of an address, a data word and a one-cycle write strobe. It recognises command sequences that begin with a two-cycle unlock prefix, and from them it launches word or byte programming, whole-array erase and multi-sector erase. It also provides an identification mode, a return to read mode, and suspend and resume of a sector erase.

The array has a top-boot layout of seven sectors. A program or erase aimed at a protected sector is dropped before it reaches the embedded-operation engine. In this block that engine is a countdown timer. When it starts an operation it reports the kind of operation, the sector mask, the address and the data. While it runs, it holds the busy flag, and it can be frozen by a suspend command.

Top module: `flash_cmd_seq`

## Requirements
- R1: While reset is asserted and in the cycle after reset is released, `busy`, `suspended`, `autosel` and `op_start` are 0 and the sequencer is in read mode.
- R2: The unlock prefix is data AAh followed by data 55h, in two separate write cycles. Only the low data byte is compared. In word mode the addresses are checked on their low 11 bits: 555h for the first cycle and 2AAh for the second. In byte mode the addresses are checked on their low 12 bits: AAAh for the first cycle and 555h for the second.
- R3: Programming is the unlock prefix, then A0h at the first unlock address, then one write carrying the target. One cycle after that write, `op_start` pulses for one cycle with `op_kind`=1 and `op_addr` equal to the target address. `op_data` is the full word in word mode and the zero-extended low byte in byte mode. `busy` is then high for exactly PROG_CYCLES cycles.
- R4: Whole-array erase is six writes: the unlock prefix, 80h, the unlock prefix again, then 10h at the first unlock address. One cycle after the last write, `op_start` pulses with `op_kind`=2 and `op_sectors` set to every unprotected sector. `busy` is then high for ERASE_CYCLES cycles.
- R5: Sector erase ends with 30h written at any address inside the chosen sector, in place of the sixth erase write. Each further 30h write adds its sector and restarts a window of WIN_CYCLES cycles. The erase starts on the WIN_CYCLES-th clock edge after the last 30h write, with `op_kind`=3, and `busy` is then high for ERASE_CYCLES cycles.
- R6: Sectors are decoded from the word address. In byte mode the word address is the byte address shifted right by one. The ranges are: bit 0 for 00000h-07FFFh, bit 1 for 08000h-0FFFFh, bit 2 for 10000h-17FFFh, bit 3 for 18000h-1BFFFh, bit 4 for 1C000h-1CFFFh, bit 5 for 1D000h-1DFFFh, and bit 6 for 1E000h-1FFFFh.
- R7: If `prot_mask` bit i is 1, sector i is protected. A program aimed at a protected sector produces no `op_start`. Protected sectors are removed from every erase mask. An erase whose mask ends up empty produces no `op_start`.
- R8: Any write that does not match the expected step of a sequence returns the sequencer to read mode, so the sequence produces no operation. This includes a write other than 30h during the sector window. F0h written in identification mode returns the sequencer to read mode.
- R9: Writing 90h at the first unlock address after the prefix sets `autosel`. While `autosel` is set, `id_data` depends on `rd_offset`. In word mode, offset 00h gives 0004h and offset 01h gives 2251h. In byte mode, offset 00h gives 0004h and offset 02h gives 0051h. Every other offset gives 0, and `id_data` is 0 whenever `autosel` is clear.
- R10: While an operation is running or suspended, writes start no new sequence. `op_start` stays 0 and the running count is not extended.
- R11: B0h written during a running sector erase sets `suspended` and clears `busy` one cycle later, unless that write lands on the erase's final busy cycle. 30h written while suspended resumes the erase. The total number of busy cycles stays ERASE_CYCLES. B0h during a program or a whole-array erase is ignored.
- R12: `busy` and `suspended` are never high together, and `op_start` is raised only when neither was high in the previous cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| byte_mode | input | 1 | 1 selects the byte-wide bus addressing |
| wr_en | input | 1 | One-cycle write strobe |
| wr_addr | input | 18 | Write address (word address in bits 16:0 in word mode, byte address in byte mode) |
| wr_data | input | 16 | Write data |
| prot_mask | input | 7 | Per-sector protection, 1 = protected |
| rd_offset | input | 8 | Low address byte of a host read, used by identification mode |
| op_start | output | 1 | One-cycle pulse when an embedded operation starts |
| op_kind | output | 2 | Kind of the last started operation: 1 program, 2 whole-array erase, 3 sector erase |
| op_sectors | output | 7 | Sector mask of the last started operation |
| op_addr | output | 18 | Program address of the last started operation |
| op_data | output | 16 | Program data of the last started operation |
| busy | output | 1 | Embedded operation running and not suspended |
| suspended | output | 1 | Sector erase suspended |
| autosel | output | 1 | Identification mode active |
| id_data | output | 16 | Identification code for `rd_offset` |

## Verification
Two pairs of functions can fall on the same clock edge. The first pair is a suspend write and the completion of the erase count. The second pair is a sector-address write and the expiry of the sector window. The bench provokes the first pair by timing B0h from the observed `op_start` so that it is sampled on the edge where the count runs out. The design must then finish the erase and must not enter suspend. A cycle-level reference model, built from the requirements, judges both pairs on every clock. For the second pair it expects the new sector write to take precedence and to restart the window.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

  localparam int NUM_SECT = 7;

  typedef enum logic [1:0] {
    OP_NONE = 2'd0,
    OP_PROG = 2'd1,
    OP_CHIP = 2'd2,
    OP_SECT = 2'd3
  } op_kind_e;

  typedef enum logic [3:0] {
    S_READ,
    S_UNL1,
    S_UNL2,
    S_PGM_DATA,
    S_ERS_3,
    S_ERS_4,
    S_ERS_5,
    S_AUTOSEL,
    S_SECT_WIN
  } seq_state_e;

  localparam logic [7:0] CMD_UNL_A   = 8'hAA;
  localparam logic [7:0] CMD_UNL_B   = 8'h55;
  localparam logic [7:0] CMD_PROGRAM = 8'hA0;
  localparam logic [7:0] CMD_ERS_SET = 8'h80;
  localparam logic [7:0] CMD_CHIP    = 8'h10;
  localparam logic [7:0] CMD_SECTOR  = 8'h30;
  localparam logic [7:0] CMD_IDENT   = 8'h90;
  localparam logic [7:0] CMD_RESET   = 8'hF0;
  localparam logic [7:0] CMD_SUSPEND = 8'hB0;

  // Top-boot layout: three large, one medium, two small, one boot-sized sector.
  function automatic logic [2:0] sector_index(input logic [16:0] wa);
    logic [2:0] idx;
    case (wa[16:15])
      2'b00:   idx = 3'd0;
      2'b01:   idx = 3'd1;
      2'b10:   idx = 3'd2;
      default: begin
        if (!wa[14])          idx = 3'd3;
        else if (wa[13:12] == 2'b00) idx = 3'd4;
        else if (wa[13:12] == 2'b01) idx = 3'd5;
        else                  idx = 3'd6;
      end
    endcase
    return idx;
  endfunction

endpackage

// File: rtl/fcs_bus_dec.sv
module fcs_bus_dec
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W = 18,
  parameter int DATA_W = 16
) (
  input  logic              byte_mode,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              hit_unl1,
  output logic              hit_unl2,
  output logic [7:0]        cmd,
  output logic [NUM_SECT-1:0] sect_hot
);

  localparam int WA_W = ADDR_W - 1;

  logic [WA_W-1:0] word_addr;
  logic [2:0]      idx;

  assign word_addr = byte_mode ? wr_addr[ADDR_W-1:1] : wr_addr[WA_W-1:0];
  assign cmd       = wr_data[7:0];
  assign hit_unl1  = byte_mode ? (wr_addr[11:0] == 12'hAAA) : (wr_addr[10:0] == 11'h555);
  assign hit_unl2  = byte_mode ? (wr_addr[11:0] == 12'h555) : (wr_addr[10:0] == 11'h2AA);
  assign idx       = sector_index(word_addr[16:0]);

  for (genvar g = 0; g < NUM_SECT; g++) begin : g_hot
    assign sect_hot[g] = (idx == 3'(g));
  end

endmodule

// File: rtl/fcs_seq_fsm.sv
module fcs_seq_fsm
  import flash_cmd_pkg::*;
#(
  parameter int WIN_CYCLES = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic                hit_unl1,
  input  logic                hit_unl2,
  input  logic [7:0]          cmd,
  input  logic [NUM_SECT-1:0] sect_hot,
  input  logic [NUM_SECT-1:0] prot_mask,
  input  logic                eng_active,
  input  logic                eng_susp,
  input  logic                eng_last,
  input  op_kind_e            eng_kind,
  output logic                start_req,
  output op_kind_e            start_kind,
  output logic [NUM_SECT-1:0] start_mask,
  output logic                susp_req,
  output logic                resume_req,
  output logic                in_autosel
);

  localparam int WW = (WIN_CYCLES > 1) ? $clog2(WIN_CYCLES) : 1;
  localparam logic [WW-1:0] WIN_LOAD = WW'(WIN_CYCLES - 1);

  seq_state_e          state_q, state_d;
  logic [WW-1:0]       win_q, win_d;
  logic [NUM_SECT-1:0] acc_q, acc_d;
  logic [NUM_SECT-1:0] live_sect;
  logic [NUM_SECT-1:0] chip_mask;

  assign live_sect = sect_hot & ~prot_mask;
  assign chip_mask = ~prot_mask;

  always_comb begin
    state_d    = state_q;
    win_d      = win_q;
    acc_d      = acc_q;
    start_req  = 1'b0;
    start_kind = OP_NONE;
    start_mask = '0;
    susp_req   = 1'b0;
    resume_req = 1'b0;
    if (eng_active) begin
      state_d = S_READ;
      if (wr_en) begin
        if (!eng_susp && eng_kind == OP_SECT && !eng_last && cmd == CMD_SUSPEND)
          susp_req = 1'b1;
        else if (eng_susp && cmd == CMD_SECTOR)
          resume_req = 1'b1;
      end
    end else if (wr_en) begin
      case (state_q)
        S_READ:     if (hit_unl1 && cmd == CMD_UNL_A) state_d = S_UNL1;
        S_UNL1:     state_d = (hit_unl2 && cmd == CMD_UNL_B) ? S_UNL2 : S_READ;
        S_UNL2: begin
          if (hit_unl1 && cmd == CMD_PROGRAM)      state_d = S_PGM_DATA;
          else if (hit_unl1 && cmd == CMD_ERS_SET) state_d = S_ERS_3;
          else if (hit_unl1 && cmd == CMD_IDENT)   state_d = S_AUTOSEL;
          else                                     state_d = S_READ;
        end
        S_PGM_DATA: begin
          state_d = S_READ;
          if (live_sect != '0) begin
            start_req  = 1'b1;
            start_kind = OP_PROG;
            start_mask = sect_hot;
          end
        end
        S_ERS_3:    state_d = (hit_unl1 && cmd == CMD_UNL_A) ? S_ERS_4 : S_READ;
        S_ERS_4:    state_d = (hit_unl2 && cmd == CMD_UNL_B) ? S_ERS_5 : S_READ;
        S_ERS_5: begin
          state_d = S_READ;
          if (hit_unl1 && cmd == CMD_CHIP) begin
            if (chip_mask != '0) begin
              start_req  = 1'b1;
              start_kind = OP_CHIP;
              start_mask = chip_mask;
            end
          end else if (cmd == CMD_SECTOR) begin
            state_d = S_SECT_WIN;
            acc_d   = live_sect;
            win_d   = WIN_LOAD;
          end
        end
        S_AUTOSEL:  if (cmd == CMD_RESET) state_d = S_READ;
        S_SECT_WIN: begin
          if (cmd == CMD_SECTOR) begin
            acc_d = acc_q | live_sect;
            win_d = WIN_LOAD;
          end else begin
            state_d = S_READ;
          end
        end
        default:    state_d = S_READ;
      endcase
    end else if (state_q == S_SECT_WIN) begin
      if (win_q == '0) begin
        state_d = S_READ;
        if (acc_q != '0) begin
          start_req  = 1'b1;
          start_kind = OP_SECT;
          start_mask = acc_q;
        end
      end else begin
        win_d = win_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_READ;
      win_q   <= '0;
      acc_q   <= '0;
    end else begin
      state_q <= state_d;
      win_q   <= win_d;
      acc_q   <= acc_d;
    end
  end

  assign in_autosel = (state_q == S_AUTOSEL);

endmodule

// File: rtl/fcs_op_engine.sv
module fcs_op_engine
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W       = 18,
  parameter int DATA_W       = 16,
  parameter int PROG_CYCLES  = 6,
  parameter int ERASE_CYCLES = 40
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start_req,
  input  op_kind_e            start_kind,
  input  logic [NUM_SECT-1:0] start_mask,
  input  logic [ADDR_W-1:0]   start_addr,
  input  logic [DATA_W-1:0]   start_data,
  input  logic                susp_req,
  input  logic                resume_req,
  output logic                active,
  output logic                susp,
  output logic                last,
  output op_kind_e            kind,
  output logic [NUM_SECT-1:0] mask,
  output logic [ADDR_W-1:0]   addr,
  output logic [DATA_W-1:0]   data,
  output logic                start_pulse
);

  localparam int MAXC = (PROG_CYCLES > ERASE_CYCLES) ? PROG_CYCLES : ERASE_CYCLES;
  localparam int CW   = $clog2(MAXC + 1);
  localparam logic [CW-1:0] PROG_LOAD = CW'(PROG_CYCLES - 1);
  localparam logic [CW-1:0] ERS_LOAD  = CW'(ERASE_CYCLES - 1);

  logic                run_q, run_d;
  logic                susp_q, susp_d;
  logic [CW-1:0]       cnt_q, cnt_d;
  op_kind_e            kind_q;
  logic [NUM_SECT-1:0] mask_q;
  logic [ADDR_W-1:0]   addr_q;
  logic [DATA_W-1:0]   data_q;
  logic                pulse_q;

  always_comb begin
    run_d  = run_q;
    cnt_d  = cnt_q;
    susp_d = susp_q;
    if (start_req) begin
      run_d = 1'b1;
      cnt_d = (start_kind == OP_PROG) ? PROG_LOAD : ERS_LOAD;
    end else if (run_q && !susp_q) begin
      if (cnt_q == '0) run_d = 1'b0;
      else             cnt_d = cnt_q - 1'b1;
    end
    if (susp_req)   susp_d = 1'b1;
    if (resume_req) susp_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q   <= 1'b0;
      susp_q  <= 1'b0;
      cnt_q   <= '0;
      pulse_q <= 1'b0;
    end else begin
      run_q   <= run_d;
      susp_q  <= susp_d;
      cnt_q   <= cnt_d;
      pulse_q <= start_req;
    end
  end

  // Operation descriptor, loaded only when a start is granted.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kind_q <= OP_NONE;
      mask_q <= '0;
      addr_q <= '0;
      data_q <= '0;
    end else if (start_req) begin
      kind_q <= start_kind;
      mask_q <= start_mask;
      addr_q <= start_addr;
      data_q <= start_data;
    end
  end

  assign active      = run_q;
  assign susp        = susp_q;
  assign last        = (cnt_q == '0);
  assign kind        = kind_q;
  assign mask        = mask_q;
  assign addr        = addr_q;
  assign data        = data_q;
  assign start_pulse = pulse_q;

endmodule

// File: rtl/fcs_id_rom.sv
module fcs_id_rom #(
  parameter logic [15:0] MFR_ID = 16'h0004,
  parameter logic [15:0] DEV_ID = 16'h2251
) (
  input  logic        enable,
  input  logic        byte_mode,
  input  logic [7:0]  rd_offset,
  output logic [15:0] id_data
);

  always_comb begin
    id_data = '0;
    if (enable) begin
      if (rd_offset == 8'h00)
        id_data = byte_mode ? {8'h00, MFR_ID[7:0]} : MFR_ID;
      else if (!byte_mode && rd_offset == 8'h01)
        id_data = DEV_ID;
      else if (byte_mode && rd_offset == 8'h02)
        id_data = {8'h00, DEV_ID[7:0]};
    end
  end

endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
  import flash_cmd_pkg::*;
#(
  parameter int          ADDR_W       = 18,
  parameter int          DATA_W       = 16,
  parameter int          PROG_CYCLES  = 6,
  parameter int          ERASE_CYCLES = 40,
  parameter int          WIN_CYCLES   = 8,
  parameter logic [15:0] MFR_ID       = 16'h0004,
  parameter logic [15:0] DEV_ID       = 16'h2251
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              byte_mode,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [6:0]        prot_mask,
  input  logic [7:0]        rd_offset,
  output logic              op_start,
  output logic [1:0]        op_kind,
  output logic [6:0]        op_sectors,
  output logic [ADDR_W-1:0] op_addr,
  output logic [DATA_W-1:0] op_data,
  output logic              busy,
  output logic              suspended,
  output logic              autosel,
  output logic [15:0]       id_data
);

  logic                hit_unl1, hit_unl2;
  logic [7:0]          cmd;
  logic [NUM_SECT-1:0] sect_hot;
  logic                start_req, susp_req, resume_req, in_autosel;
  op_kind_e            start_kind, eng_kind;
  logic [NUM_SECT-1:0] start_mask;
  logic                eng_active, eng_susp, eng_last;
  logic [DATA_W-1:0]   prog_data;

  assign prog_data = byte_mode ? {{(DATA_W-8){1'b0}}, wr_data[7:0]} : wr_data;

  fcs_bus_dec #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dec (
    .byte_mode (byte_mode),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .hit_unl1  (hit_unl1),
    .hit_unl2  (hit_unl2),
    .cmd       (cmd),
    .sect_hot  (sect_hot)
  );

  fcs_seq_fsm #(.WIN_CYCLES(WIN_CYCLES)) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .hit_unl1   (hit_unl1),
    .hit_unl2   (hit_unl2),
    .cmd        (cmd),
    .sect_hot   (sect_hot),
    .prot_mask  (prot_mask),
    .eng_active (eng_active),
    .eng_susp   (eng_susp),
    .eng_last   (eng_last),
    .eng_kind   (eng_kind),
    .start_req  (start_req),
    .start_kind (start_kind),
    .start_mask (start_mask),
    .susp_req   (susp_req),
    .resume_req (resume_req),
    .in_autosel (in_autosel)
  );

  fcs_op_engine #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .PROG_CYCLES(PROG_CYCLES), .ERASE_CYCLES(ERASE_CYCLES)
  ) u_eng (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_req   (start_req),
    .start_kind  (start_kind),
    .start_mask  (start_mask),
    .start_addr  (wr_addr),
    .start_data  (prog_data),
    .susp_req    (susp_req),
    .resume_req  (resume_req),
    .active      (eng_active),
    .susp        (eng_susp),
    .last        (eng_last),
    .kind        (eng_kind),
    .mask        (op_sectors),
    .addr        (op_addr),
    .data        (op_data),
    .start_pulse (op_start)
  );

  fcs_id_rom #(.MFR_ID(MFR_ID), .DEV_ID(DEV_ID)) u_id (
    .enable    (in_autosel),
    .byte_mode (byte_mode),
    .rd_offset (rd_offset),
    .id_data   (id_data)
  );

  assign op_kind   = eng_kind;
  assign busy      = eng_active & ~eng_susp;
  assign suspended = eng_susp;
  assign autosel   = in_autosel;

endmodule

// File: rtl/fcs_checker.sv
module fcs_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       op_start,
  input logic [1:0] op_kind,
  input logic [6:0] op_sectors,
  input logic [6:0] prot_mask,
  input logic       busy,
  input logic       suspended,
  input logic       autosel
);

  assert_excl_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && suspended));

  assert_start_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
    op_start |-> (!$past(busy) && !$past(suspended)));

  assert_start_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
    op_start |-> busy);

  assert_susp_entry_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(suspended) |-> ($past(busy) && op_kind == 2'd3));

  assert_susp_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (suspended && $past(suspended)) |-> ($stable(op_sectors) && !op_start));

  assert_no_prot_erase_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (op_start && op_kind != 2'd1) |-> ((op_sectors & prot_mask) == 7'd0));

  assert_ident_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    autosel |-> (!busy && !suspended));

endmodule

bind flash_cmd_seq fcs_checker u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .op_start   (op_start),
  .op_kind    (op_kind),
  .op_sectors (op_sectors),
  .prot_mask  (prot_mask),
  .busy       (busy),
  .suspended  (suspended),
  .autosel    (autosel)
);

// File: tb/flash_cmd_seq_test.sv
`timescale 1ns/100ps
module flash_cmd_seq_test;

  localparam int PROG  = 6;
  localparam int ERASE = 40;
  localparam int WIN   = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        byte_mode = 1'b0;
  logic        wr_en = 1'b0;
  logic [17:0] wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [6:0]  prot_mask = '0;
  logic [7:0]  rd_offset = '0;
  logic        op_start, busy, suspended, autosel;
  logic [1:0]  op_kind;
  logic [6:0]  op_sectors;
  logic [17:0] op_addr;
  logic [15:0] op_data;
  logic [15:0] id_data;

  always #2 clk = ~clk;

  flash_cmd_seq #(.PROG_CYCLES(PROG), .ERASE_CYCLES(ERASE), .WIN_CYCLES(WIN)) uut (
    .clk(clk), .rst_n(rst_n), .byte_mode(byte_mode), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .prot_mask(prot_mask),
    .rd_offset(rd_offset), .op_start(op_start), .op_kind(op_kind),
    .op_sectors(op_sectors), .op_addr(op_addr), .op_data(op_data),
    .busy(busy), .suspended(suspended), .autosel(autosel), .id_data(id_data)
  );

  int checks = 0;
  int failures = 0;
  bit cmp_on = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  localparam int M_READ = 0, M_U1 = 1, M_U2 = 2, M_PGM = 3, M_E3 = 4, M_E4 = 5,
                 M_E5 = 6, M_ID = 7, M_WIN = 8;
  int          m_st, m_win, m_rem, m_kind;
  bit          m_run, m_susp, m_start;
  logic [6:0]  m_mask, m_acc;
  logic [17:0] m_addr;
  logic [15:0] m_data;

  function automatic int ref_sector(input logic [16:0] wa);
    if (wa < 17'h08000) return 0;
    if (wa < 17'h10000) return 1;
    if (wa < 17'h18000) return 2;
    if (wa < 17'h1C000) return 3;
    if (wa < 17'h1D000) return 4;
    if (wa < 17'h1E000) return 5;
    return 6;
  endfunction

  task automatic launch(input int k, input logic [6:0] msk);
    m_run = 1; m_kind = k; m_mask = msk; m_start = 1;
    m_rem = (k == 1) ? PROG : ERASE;
    m_addr = wr_addr;
    m_data = byte_mode ? {8'h00, wr_data[7:0]} : wr_data;
  endtask

  task automatic model_step();
    logic [7:0]  d;
    bit          a1, a2, pre_run, pre_susp;
    int          pre_rem;
    logic [6:0]  sb;
    logic [16:0] wa;
    d  = wr_data[7:0];
    a1 = byte_mode ? (wr_addr[11:0] == 12'hAAA) : (wr_addr[10:0] == 11'h555);
    a2 = byte_mode ? (wr_addr[11:0] == 12'h555) : (wr_addr[10:0] == 11'h2AA);
    wa = byte_mode ? wr_addr[17:1] : wr_addr[16:0];
    sb = 7'(1 << ref_sector(wa));
    pre_run = m_run; pre_susp = m_susp; pre_rem = m_rem;
    m_start = 0;
    if (pre_run && !pre_susp) begin
      m_rem--;
      if (m_rem == 0) m_run = 0;
    end
    if (pre_run) begin
      m_st = M_READ;
      if (wr_en && !pre_susp && m_kind == 3 && pre_rem > 1 && d == 8'hB0) m_susp = 1;
      else if (wr_en && pre_susp && d == 8'h30) m_susp = 0;
    end else if (wr_en) begin
      case (m_st)
        M_READ: if (a1 && d == 8'hAA) m_st = M_U1;
        M_U1:   m_st = (a2 && d == 8'h55) ? M_U2 : M_READ;
        M_U2:   m_st = !a1 ? M_READ : (d == 8'hA0) ? M_PGM : (d == 8'h80) ? M_E3 :
                       (d == 8'h90) ? M_ID : M_READ;
        M_PGM:  begin m_st = M_READ; if ((sb & prot_mask) == 0) launch(1, sb); end
        M_E3:   m_st = (a1 && d == 8'hAA) ? M_E4 : M_READ;
        M_E4:   m_st = (a2 && d == 8'h55) ? M_E5 : M_READ;
        M_E5: begin
          m_st = M_READ;
          if (a1 && d == 8'h10) begin
            if (~prot_mask != 0) launch(2, ~prot_mask);
          end else if (d == 8'h30) begin
            m_st = M_WIN; m_acc = sb & ~prot_mask; m_win = WIN;
          end
        end
        M_ID:   if (d == 8'hF0) m_st = M_READ;
        M_WIN: begin
          if (d == 8'h30) begin m_acc = m_acc | (sb & ~prot_mask); m_win = WIN; end
          else m_st = M_READ;
        end
        default: m_st = M_READ;
      endcase
    end else if (m_st == M_WIN) begin
      m_win--;
      if (m_win == 0) begin
        m_st = M_READ;
        if (m_acc != 0) launch(3, m_acc);
      end
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = M_READ; m_win = 0; m_rem = 0; m_kind = 0; m_run = 0; m_susp = 0;
      m_start = 0; m_mask = 0; m_acc = 0; m_addr = 0; m_data = 0;
    end else begin
      model_step();
    end
  end

  // ---------------- per-cycle comparison and monitor ----------------
  int          n_start = 0;
  logic [1:0]  last_kind;
  logic [6:0]  last_sect;
  logic [17:0] last_addr;
  logic [15:0] last_data;

  function automatic logic [15:0] exp_id();
    if (!(m_st == M_ID && !m_run)) return 16'h0;
    if (rd_offset == 8'h00) return 16'h0004;
    if (!byte_mode && rd_offset == 8'h01) return 16'h2251;
    if (byte_mode && rd_offset == 8'h02) return 16'h0051;
    return 16'h0;
  endfunction

  always @(negedge clk) begin
    if (rst_n && cmp_on) begin
      chk(op_start === m_start, "R3 op_start vs model", op_start, m_start);
      chk(busy === (m_run && !m_susp), "R10 busy vs model", busy, m_run && !m_susp);
      chk(suspended === m_susp, "R11 suspended vs model", suspended, m_susp);
      chk(autosel === (m_st == M_ID && !m_run), "R9 autosel vs model", autosel, m_st == M_ID);
      chk(id_data === exp_id(), "R9 id_data vs model", id_data, exp_id());
      chk(!(busy && suspended), "R12 busy and suspended together", {busy, suspended}, 2'b00);
      if (m_start) begin
        chk(op_kind === 2'(m_kind), "R5 op_kind vs model", op_kind, m_kind);
        chk(op_sectors === m_mask, "R6 op_sectors vs model", op_sectors, m_mask);
        if (m_kind == 1) begin
          chk(op_addr === m_addr, "R3 op_addr vs model", op_addr, m_addr);
          chk(op_data === m_data, "R3 op_data vs model", op_data, m_data);
        end
      end
    end
    if (rst_n && op_start) begin
      n_start++;
      last_kind = op_kind; last_sect = op_sectors;
      last_addr = op_addr; last_data = op_data;
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic wr(input logic [17:0] a, input logic [15:0] d);
    @(negedge clk); #1;
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic unlock();
    if (byte_mode) begin wr(18'hAAA, 16'hAA); wr(18'h555, 16'h55); end
    else           begin wr(18'h555, 16'hAA); wr(18'h2AA, 16'h55); end
  endtask

  function automatic logic [17:0] a1addr();
    return byte_mode ? 18'hAAA : 18'h555;
  endfunction

  task automatic wait_idle();
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      if (!busy && !suspended) break;
    end
  endtask

  task automatic erase_prefix();
    unlock(); wr(a1addr(), 16'h80); unlock();
  endtask

  initial begin
    #(4 * 200000);
    chk(0, "watchdog expired", 0, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int base;
    int cnt;
    idle(2);
    chk({busy, suspended, autosel, op_start} == 4'b0, "R1 outputs in reset",
        {busy, suspended, autosel, op_start}, 0);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk({busy, suspended, autosel, op_start} == 4'b0, "R1 outputs after reset",
        {busy, suspended, autosel, op_start}, 0);
    cmp_on = 1;

    // R3 word program, busy length
    base = n_start;
    unlock(); wr(18'h555, 16'hA0); wr(18'h00100, 16'h1234);
    chk(op_start && n_start == base + 1, "R3 program start pulse", n_start - base, 1);
    cnt = 0;
    while (busy) begin cnt++; @(negedge clk); end
    chk(cnt == PROG, "R3 program busy cycles", cnt, PROG);
    chk(last_kind == 2'd1 && last_data == 16'h1234, "R3 program descriptor", last_data, 16'h1234);

    // R4 whole-array erase with protection
    prot_mask = 7'b0000101;
    base = n_start;
    erase_prefix(); wr(18'h555, 16'h10);
    wait_idle();
    chk(n_start == base + 1 && last_kind == 2'd2, "R4 chip erase started", last_kind, 2);
    chk(last_sect == 7'b1111010, "R4 chip erase mask", last_sect, 7'b1111010);

    // R5/R6 multi-sector erase with boundary addresses
    prot_mask = 7'b0000000;
    base = n_start;
    erase_prefix(); wr(18'h1E000, 16'h30); wr(18'h1CFFF, 16'h30); wr(18'h08000, 16'h30);
    idle(WIN + 2);
    chk(n_start == base + 1 && last_kind == 2'd3, "R5 sector erase started", n_start - base, 1);
    chk(last_sect == 7'b1010010, "R6 sectors 6,4,1", last_sect, 7'b1010010);
    wait_idle();
    base = n_start;
    erase_prefix(); wr(18'h1BFFF, 16'h30); idle(WIN - 2); wr(18'h1D000, 16'h30);
    idle(WIN - 2); wr(18'h17FFF, 16'h30);
    idle(WIN + 2);
    chk(n_start == base + 1, "R5 window restart keeps one start", n_start - base, 1);
    chk(last_sect == 7'b0101100, "R6 sectors 5,3,2", last_sect, 7'b0101100);
    wait_idle();

    // R7 protection
    prot_mask = 7'b1000000;
    base = n_start;
    unlock(); wr(18'h555, 16'hA0); wr(18'h1F000, 16'hBEEF); idle(3);
    chk(n_start == base && !busy, "R7 program to protected sector", n_start - base, 0);
    erase_prefix(); wr(18'h1E800, 16'h30); idle(WIN + 3);
    chk(n_start == base && !busy, "R7 erase of protected sector only", n_start - base, 0);
    prot_mask = 7'b0000000;

    // R8 aborts
    base = n_start;
    wr(18'h555, 16'hAA); wr(18'h2AA, 16'h54); wr(18'h555, 16'hA0); wr(18'h00100, 16'hBEEF);
    idle(3);
    chk(n_start == base, "R8 bad unlock aborts", n_start - base, 0);
    erase_prefix(); wr(18'h10000, 16'h30); wr(18'h10000, 16'hF0); idle(WIN + 3);
    chk(n_start == base && !busy, "R8 window abort", n_start - base, 0);

    // R9 identification, word then byte mode
    unlock(); wr(18'h555, 16'h90);
    rd_offset = 8'h01; @(negedge clk);
    chk(autosel && id_data == 16'h2251, "R9 word device code", id_data, 16'h2251);
    rd_offset = 8'h00; @(negedge clk);
    chk(id_data == 16'h0004, "R9 word maker code", id_data, 16'h0004);
    rd_offset = 8'h05; @(negedge clk);
    chk(id_data == 16'h0000, "R9 unused offset", id_data, 0);
    wr(18'h0, 16'hF0);
    chk(!autosel, "R8 F0 exits identification", autosel, 0);
    byte_mode = 1'b1;
    unlock(); wr(18'hAAA, 16'h90);
    rd_offset = 8'h02; @(negedge clk);
    chk(id_data == 16'h0051, "R9 byte device code", id_data, 16'h0051);
    wr(18'h0, 16'hF0);

    // R2 byte-mode program
    base = n_start;
    unlock(); wr(18'hAAA, 16'hA0); wr(18'h00201, 16'hFF5A);
    chk(n_start == base + 1 && last_data == 16'h005A && last_addr == 18'h00201,
        "R2 byte mode program", last_data, 16'h005A);
    wait_idle();
    base = n_start;
    wr(18'h555, 16'hAA); wr(18'h2AA, 16'h55); wr(18'h555, 16'hA0); wr(18'h00300, 16'h0011);
    idle(3);
    chk(n_start == base, "R2 word addresses rejected in byte mode", n_start - base, 0);
    byte_mode = 1'b0;
    rd_offset = 8'h00;

    // R10 sequences ignored while busy
    base = n_start;
    erase_prefix(); wr(18'h555, 16'h10);
    unlock(); wr(18'h555, 16'hA0); wr(18'h00400, 16'h7777);
    wait_idle();
    chk(n_start == base + 1 && last_kind == 2'd2, "R10 no start while busy", n_start - base, 1);

    // R11 B0 during program ignored
    unlock(); wr(18'h555, 16'hA0); wr(18'h00500, 16'h0001); wr(18'h0, 16'hB0);
    chk(!suspended, "R11 suspend ignored for program", suspended, 0);
    wait_idle();

    // R11 suspend and resume of a sector erase
    erase_prefix(); wr(18'h10000, 16'h30);
    do @(negedge clk); while (!op_start);
    idle(5); wr(18'h0, 16'hB0);
    chk(suspended && !busy, "R11 suspended after B0", suspended, 1);
    idle(20);
    chk(suspended, "R11 stays suspended", suspended, 1);
    unlock(); wr(18'h555, 16'hA0); wr(18'h00600, 16'h0002);
    chk(suspended, "R10 program ignored while suspended", suspended, 1);
    wr(18'h0, 16'h30);
    chk(busy && !suspended, "R11 resumed", busy, 1);
    wait_idle();

    // R11 suspend landing on final busy cycle
    erase_prefix(); wr(18'h08000, 16'h30);
    do @(negedge clk); while (!op_start);
    idle(ERASE - 2); wr(18'h0, 16'hB0);
    chk(!suspended && !busy, "R11 late suspend ignored at completion", suspended, 0);
    idle(4);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule